// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for two independent requesters, an instruction-fetch side and a data side. Each side owns a small fully associative first-level buffer that answers in the same cycle as the request. Both first-level buffers share one second-level buffer, which holds a two-way set-associative array and a small fully associative section for pinned translations.

A requester raises its request with an address and keeps both steady until its hit output is seen. On a first-level miss the second level is searched in the same cycle. If it holds the page, the first-level buffer of that side is refilled at the clock edge and the hit follows one cycle later. If the second level misses too, the block raises a walk request carrying the virtual page number. The external page walker answers with a one-cycle response that gives the physical page and a lock flag. A single invalidate input empties the whole hierarchy. Pages are 4 KB, so the low 12 address bits pass through unchanged.

Top module: `tlb_two_level`

## Requirements
- R1: After reset no page is held: every request misses, a requesting side stalls, and with no request active, hit, stall and walk request are all low.
- R2: When a side's first-level buffer holds the page of its request, its hit output is high in that same cycle and its physical address equals the stored 20-bit physical page followed by the request's low 12 address bits.
- R3: When a side misses in its first level but the second level holds the page, that side's first level is written at the clock edge and a held request hits in the next cycle, with no walk request raised.
- R4: When both sides miss their first level in the same cycle, the data side is served by the second level first; the instruction side is served in a later cycle.
- R5: When the served side misses in both levels, walk request is high with walk page equal to bits 31:12 of that side's address, and it stays high until a walker response fills the page.
- R6: A walker response with the lock flag low is written into the set given by page bits 4:0; an empty way is used first (way 0 before way 1), otherwise the way named by the set's replacement bit, which then points at the other way; a second-level hit served to a side also points that bit at the way not hit.
- R7: A walker response with the lock flag high is written into the 8-entry fully associative section in round-robin order, so pinned pages are never displaced by set conflicts.
- R8: Each first-level buffer holds 10 pages and replaces them in round-robin fill order, so the eleventh distinct fill overwrites the first.
- R9: Invalidate-all clears every entry of both levels at the clock edge; in that cycle no first-level fill is made, no walker response is written and walk request is low, while hit outputs still reflect the old contents.
- R10: Stall is high exactly when some side has its request high and its hit low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Instruction-side lookup request |
| i_va | input | 32 | Instruction-side virtual address |
| d_req | input | 1 | Data-side lookup request |
| d_va | input | 32 | Data-side virtual address |
| inv_all | input | 1 | Invalidate every entry of both levels |
| walk_rsp_valid | input | 1 | Walker response strobe |
| walk_rsp_vpn | input | 20 | Virtual page of the response |
| walk_rsp_ppn | input | 20 | Physical page of the response |
| walk_rsp_locked | input | 1 | Response is pinned into the fully associative section |
| i_hit | output | 1 | Instruction-side translation valid |
| i_pa | output | 32 | Instruction-side physical address |
| d_hit | output | 1 | Data-side translation valid |
| d_pa | output | 32 | Data-side physical address |
| stall | output | 1 | Some requesting side has no translation |
| walk_req | output | 1 | Page walk needed |
| walk_vpn | output | 20 | Virtual page to walk |

## Verification
A wrong replacement pointer, replacement bit or valid bit in either level does not show at once; it shows on the first later revisit of an evicted or surviving page, as a hit where a walk was due or as a walk request where a hit was due. The stimulus therefore overfills each first-level buffer, drives three pages into one set and more pinned pages than the pinned section holds, and then revisits them, so such faults surface within a few cycles of the revisit. Priority faults show in the very cycle both sides miss, through the walk page value, and a missed invalidate shows as a hit in the cycle after the pulse.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
   typedef enum logic [1:0] {
      SVC_NONE = 2'd0,
      SVC_INST = 2'd1,
      SVC_DATA = 2'd2
   } svc_e;

   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
      return (v == n - 1) ? 0 : v + 1;
   endfunction
endpackage

// File: rtl/tlb2_micro.sv
module tlb2_micro #(
   parameter int ENTRIES = 10,
   parameter int VPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [VPN_W-1:0] hit_ppn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [VPN_W-1:0] fill_ppn
);
   localparam int PTR_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] val_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [VPN_W-1:0]   ppn_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] match;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = val_q[e] && (vpn_q[e] == lk_vpn);
   end

   always_comb begin
      hit_ppn = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (match[e]) hit_ppn = hit_ppn | ppn_q[e];
   end
   assign hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         ptr_q <= '0;
      end else if (inv) begin
         val_q <= '0;
      end else if (fill_en) begin
         val_q[ptr_q] <= 1'b1;
         vpn_q[ptr_q] <= fill_vpn;
         ppn_q[ptr_q] <= fill_ppn;
         ptr_q <= PTR_W'(tlb2_pkg::wrap_inc(32'(ptr_q), ENTRIES));
      end
   end

   AST_MICRO_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R3
   AST_MICRO_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr_q) < ENTRIES); // R8
   AST_MICRO_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      inv |=> (val_q == '0)); // R9
endmodule

// File: rtl/tlb2_main.sv
module tlb2_main #(
   parameter int SETS   = 32,
   parameter int LOCK_N = 8,
   parameter int VPN_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_use,
   output logic             hit,
   output logic [VPN_W-1:0] hit_ppn,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [VPN_W-1:0] wr_ppn,
   input  logic             wr_lock
);
   localparam int IDX_W = $clog2(SETS);
   localparam int FP_W  = $clog2(LOCK_N);
   localparam int WAYS  = 2;

   logic [SETS-1:0]   sval [WAYS];
   logic [VPN_W-1:0]  stag [WAYS][SETS];
   logic [VPN_W-1:0]  sppn [WAYS][SETS];
   logic [SETS-1:0]   lru_q;
   logic [LOCK_N-1:0] fval;
   logic [VPN_W-1:0]  fvpn [LOCK_N];
   logic [VPN_W-1:0]  fppn [LOCK_N];
   logic [FP_W-1:0]   fptr_q;

   logic [IDX_W-1:0]  idx, widx;
   logic [WAYS-1:0]   smatch;
   logic [LOCK_N-1:0] fmatch;
   logic              victim;

   assign idx  = lk_vpn[IDX_W-1:0];
   assign widx = wr_vpn[IDX_W-1:0];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign smatch[w] = sval[w][idx] && (stag[w][idx] == lk_vpn);
   end
   for (genvar f = 0; f < LOCK_N; f++) begin : g_fa
      assign fmatch[f] = fval[f] && (fvpn[f] == lk_vpn);
   end

   always_comb begin
      hit_ppn = '0;
      for (int w = 0; w < WAYS; w++)
         if (smatch[w]) hit_ppn = hit_ppn | sppn[w][idx];
      for (int f = 0; f < LOCK_N; f++)
         if (fmatch[f]) hit_ppn = hit_ppn | fppn[f];
   end
   assign hit = (|smatch) || (|fmatch);

   always_comb begin
      if (!sval[0][widx])      victim = 1'b0;
      else if (!sval[1][widx]) victim = 1'b1;
      else                     victim = lru_q[widx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sval[0] <= '0;
         sval[1] <= '0;
         fval    <= '0;
         lru_q   <= '0;
         fptr_q  <= '0;
      end else if (inv) begin
         sval[0] <= '0;
         sval[1] <= '0;
         fval    <= '0;
      end else begin
         if (lk_use && (|smatch))
            lru_q[idx] <= ~smatch[1];
         if (wr_en) begin
            if (wr_lock) begin
               fval[fptr_q] <= 1'b1;
               fvpn[fptr_q] <= wr_vpn;
               fppn[fptr_q] <= wr_ppn;
               fptr_q <= FP_W'(tlb2_pkg::wrap_inc(32'(fptr_q), LOCK_N));
            end else begin
               sval[victim][widx] <= 1'b1;
               stag[victim][widx] <= wr_vpn;
               sppn[victim][widx] <= wr_ppn;
               lru_q[widx]        <= ~victim;
            end
         end
      end
   end

   AST_MAIN_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smatch, fmatch})); // R7
   AST_MAIN_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      inv |=> (sval[0] == '0 && sval[1] == '0 && fval == '0)); // R9
   AST_LRU_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inv && !wr_lock) |=> (lru_q[$past(widx)] != $past(victim))); // R6
endmodule

// File: rtl/tlb_two_level.sv
module tlb_two_level #(
   parameter int VA_W      = 32,
   parameter int PAGE_W    = 12,
   parameter int MICRO_N   = 10,
   parameter int MAIN_SETS = 32,
   parameter int LOCK_N    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   i_req,
   input  logic [VA_W-1:0]        i_va,
   input  logic                   d_req,
   input  logic [VA_W-1:0]        d_va,
   input  logic                   inv_all,
   input  logic                   walk_rsp_valid,
   input  logic [VA_W-PAGE_W-1:0] walk_rsp_vpn,
   input  logic [VA_W-PAGE_W-1:0] walk_rsp_ppn,
   input  logic                   walk_rsp_locked,
   output logic                   i_hit,
   output logic [VA_W-1:0]        i_pa,
   output logic                   d_hit,
   output logic [VA_W-1:0]        d_pa,
   output logic                   stall,
   output logic                   walk_req,
   output logic [VA_W-PAGE_W-1:0] walk_vpn
);
   import tlb2_pkg::*;

   localparam int VPN_W = VA_W - PAGE_W;
   localparam int SIDES = 2;

   if (MAIN_SETS < 2 || (MAIN_SETS & (MAIN_SETS - 1)) != 0) begin : g_bad_sets
      $error("MAIN_SETS must be a power of two of at least 2");
   end
   if (MICRO_N < 2 || LOCK_N < 2) begin : g_bad_depth
      $error("MICRO_N and LOCK_N must be at least 2");
   end
   if (VPN_W < $clog2(MAIN_SETS) + 1) begin : g_bad_width
      $error("virtual page number too narrow for the set index");
   end

   logic [SIDES-1:0] req_s, mhit, fill_s;
   logic [VPN_W-1:0] vpn_s  [SIDES];
   logic [VPN_W-1:0] mppn_s [SIDES];
   logic [PAGE_W-1:0] ofs_s [SIDES];
   svc_e             svc;
   logic [VPN_W-1:0] main_vpn, main_ppn;
   logic             main_hit;

   assign req_s  = {d_req, i_req};
   assign vpn_s[0] = i_va[VA_W-1:PAGE_W];
   assign vpn_s[1] = d_va[VA_W-1:PAGE_W];
   assign ofs_s[0] = i_va[PAGE_W-1:0];
   assign ofs_s[1] = d_va[PAGE_W-1:0];

   always_comb begin
      if (d_req && !mhit[1])      svc = SVC_DATA;
      else if (i_req && !mhit[0]) svc = SVC_INST;
      else                        svc = SVC_NONE;
   end
   assign main_vpn = (svc == SVC_DATA) ? vpn_s[1] : vpn_s[0];
   assign fill_s[0] = (svc == SVC_INST) && main_hit && !inv_all;
   assign fill_s[1] = (svc == SVC_DATA) && main_hit && !inv_all;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      tlb2_micro #(.ENTRIES(MICRO_N), .VPN_W(VPN_W)) u_micro (
         .clk      (clk),
         .rst_n    (rst_n),
         .inv      (inv_all),
         .lk_vpn   (vpn_s[s]),
         .hit      (mhit[s]),
         .hit_ppn  (mppn_s[s]),
         .fill_en  (fill_s[s]),
         .fill_vpn (vpn_s[s]),
         .fill_ppn (main_ppn)
      );
   end

   tlb2_main #(.SETS(MAIN_SETS), .LOCK_N(LOCK_N), .VPN_W(VPN_W)) u_main (
      .clk     (clk),
      .rst_n   (rst_n),
      .inv     (inv_all),
      .lk_vpn  (main_vpn),
      .lk_use  ((svc != SVC_NONE) && !inv_all),
      .hit     (main_hit),
      .hit_ppn (main_ppn),
      .wr_en   (walk_rsp_valid),
      .wr_vpn  (walk_rsp_vpn),
      .wr_ppn  (walk_rsp_ppn),
      .wr_lock (walk_rsp_locked)
   );

   assign i_hit    = req_s[0] && mhit[0];
   assign d_hit    = req_s[1] && mhit[1];
   assign i_pa     = {mppn_s[0], ofs_s[0]};
   assign d_pa     = {mppn_s[1], ofs_s[1]};
   assign stall    = (i_req && !i_hit) || (d_req && !d_hit);
   assign walk_req = (svc != SVC_NONE) && !main_hit && !inv_all;
   assign walk_vpn = main_vpn;

   AST_WALK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> stall); // R5
   AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && d_req && !d_hit) |-> (walk_vpn == d_va[VA_W-1:PAGE_W])); // R4
   AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((svc == SVC_DATA) && main_hit && !inv_all)
      |=> (!d_req || d_va != $past(d_va) || d_hit)); // R3
endmodule

// File: tb/tlb_two_level_test.sv
module tlb_two_level_test;
   localparam int CLK_PERIOD = 10;
   localparam int MN = 10, SETS = 32, LN = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic i_req = 0, d_req = 0, inv_all = 0;
   logic [31:0] i_va = '0, d_va = '0;
   logic rsp_valid = 0, rsp_lock = 0;
   logic [19:0] rsp_vpn = '0, rsp_ppn = '0;
   logic i_hit, d_hit, stall, walk_req;
   logic [31:0] i_pa, d_pa;
   logic [19:0] walk_vpn;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_two_level #(.MICRO_N(MN), .MAIN_SETS(SETS), .LOCK_N(LN)) uut (
      .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_va(i_va), .d_req(d_req), .d_va(d_va),
      .inv_all(inv_all), .walk_rsp_valid(rsp_valid), .walk_rsp_vpn(rsp_vpn),
      .walk_rsp_ppn(rsp_ppn), .walk_rsp_locked(rsp_lock), .i_hit(i_hit), .i_pa(i_pa),
      .d_hit(d_hit), .d_pa(d_pa), .stall(stall), .walk_req(walk_req), .walk_vpn(walk_vpn));

   int n_chk = 0, n_fail = 0, cyc = 0, inv_at = -1;
   string cur_tag = "R1";

   // reference model state
   logic [19:0] mi_vpn [2][MN], mi_ppn [2][MN];
   bit          mi_v   [2][MN];
   int          mi_ptr [2];
   logic [19:0] ms_vpn [2][SETS], ms_ppn [2][SETS];
   bit          ms_v   [2][SETS];
   bit          ms_lru [SETS];
   logic [19:0] fa_vpn [LN], fa_ppn [LN];
   bit          fa_v   [LN];
   int          fa_ptr = 0;

   // stimulus and walker state
   logic [19:0] iq [$], dq [$];
   int  ii = 0, di = 0;
   bit  adv_i = 0, adv_d = 0;
   bit  wk_busy = 0;
   int  wk_cnt = 0;
   logic [19:0] wk_vpn = '0;

   function automatic logic [19:0] pf(input logic [19:0] v);
      return v ^ 20'hC3A5F;
   endfunction

   function automatic bit micro_look(input int s, input logic [19:0] v, output logic [19:0] p);
      micro_look = 0; p = '0;
      for (int k = 0; k < MN; k++)
         if (mi_v[s][k] && mi_vpn[s][k] == v) begin micro_look = 1; p = mi_ppn[s][k]; end
   endfunction

   function automatic bit main_look(input logic [19:0] v, output logic [19:0] p, output int way);
      int ix = int'(v[4:0]);
      main_look = 0; p = '0; way = -2;
      for (int w = 0; w < 2; w++)
         if (ms_v[w][ix] && ms_vpn[w][ix] == v) begin main_look = 1; p = ms_ppn[w][ix]; way = w; end
      for (int f = 0; f < LN; f++)
         if (fa_v[f] && fa_vpn[f] == v) begin main_look = 1; p = fa_ppn[f]; way = -1; end
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   task automatic step();
      logic [19:0] vi, vd, sv, pi, pd, pm;
      bit ehi, ehd, mh, ewalk, estall;
      int svc, mway;
      @(negedge clk);
      rsp_valid = 0;
      if (wk_busy) begin
         wk_cnt--;
         if (wk_cnt == 0) begin
            rsp_valid = 1; rsp_vpn = wk_vpn; rsp_ppn = pf(wk_vpn);
            rsp_lock = (wk_vpn[19:16] == 4'hF); wk_busy = 0;
         end
      end
      if (adv_i) ii++;
      if (adv_d) di++;
      i_req = (ii < iq.size());
      d_req = (di < dq.size());
      i_va = {i_req ? iq[ii] : 20'h0, 12'((cyc * 53) & 12'hFFF)};
      d_va = {d_req ? dq[di] : 20'h0, 12'((cyc * 97 + 5) & 12'hFFF)};
      inv_all = (cyc == inv_at);
      #1;
      vi = i_va[31:12]; vd = d_va[31:12];
      ehi = i_req && micro_look(0, vi, pi);
      ehd = d_req && micro_look(1, vd, pd);
      svc = (d_req && !ehd) ? 2 : ((i_req && !ehi) ? 1 : 0);
      sv = (svc == 2) ? vd : vi;
      mh = (svc != 0) && main_look(sv, pm, mway);
      ewalk = (svc != 0) && !mh && !inv_all;
      estall = (i_req && !ehi) || (d_req && !ehd);
      chk(i_hit == ehi, {cur_tag, " i_hit"}, 32'(i_hit), 32'(ehi));
      chk(d_hit == ehd, {cur_tag, " d_hit"}, 32'(d_hit), 32'(ehd));
      if (ehi) chk(i_pa == {pi, i_va[11:0]}, "R2 i_pa", i_pa, {pi, i_va[11:0]});
      if (ehd) chk(d_pa == {pd, d_va[11:0]}, "R2 d_pa", d_pa, {pd, d_va[11:0]});
      chk(stall == estall, "R10 stall", 32'(stall), 32'(estall));
      chk(walk_req == ewalk, {cur_tag, " R5 walk_req"}, 32'(walk_req), 32'(ewalk));
      if (ewalk) chk(walk_vpn == sv, "R4 walk_vpn", 32'(walk_vpn), 32'(sv));
      if (!wk_busy && !rsp_valid && walk_req) begin
         wk_busy = 1; wk_cnt = 3; wk_vpn = walk_vpn;
      end
      adv_i = ehi; adv_d = ehd;
      @(posedge clk);
      if (inv_all) begin
         for (int s = 0; s < 2; s++) for (int k = 0; k < MN; k++) mi_v[s][k] = 0;
         for (int w = 0; w < 2; w++) for (int k = 0; k < SETS; k++) ms_v[w][k] = 0;
         for (int f = 0; f < LN; f++) fa_v[f] = 0;
      end else begin
         if (svc != 0 && mh) begin
            int s = svc - 1;
            mi_v[s][mi_ptr[s]] = 1; mi_vpn[s][mi_ptr[s]] = sv; mi_ppn[s][mi_ptr[s]] = pm;
            mi_ptr[s] = (mi_ptr[s] + 1) % MN;
            if (mway >= 0) ms_lru[int'(sv[4:0])] = (mway == 0);
         end
         if (rsp_valid) begin
            if (rsp_lock) begin
               fa_v[fa_ptr] = 1; fa_vpn[fa_ptr] = rsp_vpn; fa_ppn[fa_ptr] = rsp_ppn;
               fa_ptr = (fa_ptr + 1) % LN;
            end else begin
               int ix = int'(rsp_vpn[4:0]);
               int vw = !ms_v[0][ix] ? 0 : (!ms_v[1][ix] ? 1 : int'(ms_lru[ix]));
               ms_v[vw][ix] = 1; ms_vpn[vw][ix] = rsp_vpn; ms_ppn[vw][ix] = rsp_ppn;
               ms_lru[ix] = (vw == 0);
            end
         end
      end
      cyc++;
   endtask

   task automatic run_phase(input string tag);
      int guard = 0;
      cur_tag = tag; ii = 0; di = 0; adv_i = 0; adv_d = 0;
      do begin
         step(); guard++;
      end while (!((ii + int'(adv_i) >= iq.size()) && (di + int'(adv_d) >= dq.size())) && guard < 3000);
      if (guard >= 3000) chk(0, {tag, " phase timeout"}, 32'(guard), 32'd0);
   endtask

   task automatic idle(input int n);
      iq = {}; dq = {}; ii = 0; di = 0; adv_i = 0; adv_d = 0;
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      chk(0, "watchdog expired", 32'(cyc), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < 2; s++) begin
         mi_ptr[s] = 0;
         for (int k = 0; k < MN; k++) mi_v[s][k] = 0;
      end
      for (int w = 0; w < 2; w++) for (int k = 0; k < SETS; k++) ms_v[w][k] = 0;
      for (int k = 0; k < SETS; k++) ms_lru[k] = 0;
      for (int f = 0; f < LN; f++) fa_v[f] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1: idle outputs after reset
      chk(!i_hit && !d_hit, "R1 hit after reset", 32'({i_hit, d_hit}), 32'd0);
      chk(!stall && !walk_req, "R1 stall/walk idle", 32'({stall, walk_req}), 32'd0);
      // R1: first requests on an empty buffer miss and stall
      iq = {20'h00005}; dq = {20'h00006};
      run_phase("R1");
      // R4: both sides miss together, data served first; R2 reuse hits
      iq = {20'h00010, 20'h00020, 20'h00010, 20'h00020};
      dq = {20'h00010, 20'h00011, 20'h00011, 20'h00010};
      run_phase("R4");
      // R3: pages present in the second level refill the other side
      iq = {20'h00011, 20'h00006}; dq = {20'h00020, 20'h00005};
      run_phase("R3");
      // R8: overfill the instruction side, then revisit evicted pages
      iq = {};
      for (int k = 0; k < 12; k++) iq.push_back(20'h00100 + 20'(k));
      iq.push_back(20'h00100); iq.push_back(20'h00101); iq.push_back(20'h0010B);
      dq = {};
      run_phase("R8");
      // R6: three pages in set 5, flood the data side, then revisit
      dq = {20'h00205, 20'h00405, 20'h00205, 20'h00605};
      for (int k = 0; k < 10; k++) dq.push_back(20'h00300 + 20'(k) * 20'h20);
      dq.push_back(20'h00405); dq.push_back(20'h00205); dq.push_back(20'h00605);
      iq = {};
      run_phase("R6");
      // R7: more pinned pages than the pinned section, all in set 5
      dq = {};
      for (int k = 0; k < 10; k++) dq.push_back(20'hF0005 + 20'(k) * 20'h200);
      for (int k = 0; k < 10; k++) dq.push_back(20'h00700 + 20'(k) * 20'h20);
      for (int k = 0; k < 10; k++) dq.push_back(20'hF0005 + 20'(k) * 20'h200);
      iq = {20'h00205, 20'h00605};
      run_phase("R7");
      // R9: invalidate while requests run, then an idle invalidate
      iq = {20'h00010, 20'h00100, 20'h00010, 20'h00101};
      dq = {20'h00011, 20'hF0005, 20'h00011};
      inv_at = cyc + 2;
      run_phase("R9");
      idle(2);
      inv_at = cyc;
      idle(1);
      iq = {20'h00010}; dq = {20'h00011};
      run_phase("R9");
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule